// File: doc/BRIEF.md
# Endpoint Handshake Responder

This block is the device-side decision logic for endpoint transactions on a token-based serial bus. A transaction comes in already decoded: which endpoint, whether the host is reading (IN) or writing (OUT), whether the data packet's CRC checked out, which data sequence value it carried, and two readiness flags. The data-pending flag says the endpoint has data to send. The buffer-ready flag says it can take data. From these and its own per-endpoint state, the block picks the handshake the device answers with. It can also ask for a data packet to be sent, or tell the buffer to keep the received data.

Each endpoint keeps two state bits. One is a halt flag, which forces STALL until the host clears it. The other is a sequence (toggle) bit, which keeps the device in step with the host so that a repeated packet is not taken twice. The host changes this state through a small command port: set halt, clear halt, or reset the toggle. When the host acknowledges data the device sent on an IN transaction, that arrives as a separate strobe, and the endpoint's toggle then advances.

A parameter mask marks endpoints that never handshake. These endpoints answer with the "none" code and never change their toggle bit.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: While an endpoint's halt flag is set, every transaction to it answers STALL (code 3). There is no transmit request, no accept, and its toggle does not change. A host acknowledge to a halted endpoint leaves its toggle unchanged.
- R2: Command op 1 sets the addressed endpoint's halt flag. The flag then stays set until a command with op 2 (clear halt) addresses that endpoint. Transactions and idle cycles do not clear it.
- R3: Clear halt (op 2) also forces that endpoint's toggle to 0 (DATA0). Op 3 forces the toggle to 0 and leaves the halt flag alone.
- R4: An OUT transaction whose CRC flag is low gets no handshake (code 0). It is not accepted and the toggle does not change.
- R5: A valid OUT transaction while the buffer-ready flag is low answers NAK (code 2). It is not accepted and the toggle does not change.
- R6: A valid OUT transaction with the buffer ready, whose data PID bit (0 = DATA0, 1 = DATA1) equals the endpoint's toggle, answers ACK (code 1). The data is accepted and the toggle inverts.
- R7: A valid OUT transaction with the buffer ready, whose data PID bit differs from the toggle, answers ACK. The data is not accepted and the toggle does not change.
- R8: An IN transaction with no pending data answers NAK and asks for no transmission.
- R9: An IN transaction with pending data raises the transmit request, with the transmit PID bit equal to the endpoint's toggle, and gives code 0. The toggle inverts only when a host acknowledge strobe names that endpoint.
- R10: An endpoint flagged in the no-handshake mask (default: endpoint 3), when not halted, always gives code 0. A CRC-valid OUT with the buffer ready is accepted whatever its PID bit. An IN with data pending raises the transmit request. Neither traffic nor host acknowledges change its toggle.
- R11: The handshake, transmit and accept outputs, together with a result-valid strobe, appear in the cycle after the transaction is presented. Toggle and halt outputs change at that same edge.
- R12: When a transaction and a toggle-writing command (op 2 or 3) address the same endpoint in one cycle, the transaction is decided on the old state and the command's value wins for the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| txn_valid_i | input | 1 | A decoded transaction is presented this cycle |
| txn_ep_i | input | EP_W | Target endpoint of the transaction |
| txn_in_i | input | 1 | 1 = IN (device sends), 0 = OUT (device receives) |
| crc_ok_i | input | 1 | Received data packet passed its CRC check |
| data_pid_i | input | 1 | Sequence bit of the received data packet |
| pending_i | input | 1 | Endpoint has data ready to send |
| buf_ready_i | input | 1 | Endpoint buffer can take an OUT packet |
| hack_valid_i | input | 1 | Host acknowledged the device's last IN data |
| hack_ep_i | input | EP_W | Endpoint the host acknowledge refers to |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_ep_i | input | EP_W | Endpoint the command addresses |
| cmd_op_i | input | 2 | 0 none, 1 set halt, 2 clear halt, 3 reset toggle |
| hs_valid_o | output | 1 | Result of the previous cycle's transaction is valid |
| hs_code_o | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| tx_req_o | output | 1 | Send a data packet |
| tx_pid_o | output | 1 | Sequence bit for the data packet to send |
| accept_o | output | 1 | Keep the received OUT data |
| toggle_o | output | NUM_EP | Per-endpoint toggle bits |
| halt_o | output | NUM_EP | Per-endpoint halt flags |

## Verification
Every transaction result is due exactly one clock after the transaction is presented. The toggle and halt vectors take their new values at that same edge, and commands and host acknowledges become visible one edge after they are driven. The bench drives each stimulus on a falling edge, holds it across one rising edge, and samples all outputs at the next falling edge. At that point exactly one register stage has updated. Same-cycle conflicts between a transaction and a command are driven together in one cycle, so the result shows both the decision taken on the old state and the command's final toggle value.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        CMD_NOP      = 2'd0,
        CMD_SET_HALT = 2'd1,
        CMD_CLR_HALT = 2'd2,
        CMD_RST_TOG  = 2'd3
    } cmd_op_e;

    typedef struct packed {
        logic halt;
        logic tog;
    } ep_state_t;

    typedef struct packed {
        logic     valid;
        hs_code_e code;
        logic     tx;
        logic     tx_pid;
        logic     acc;
    } hs_result_t;

endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import ep_hs_pkg::*;
(
    input  logic     is_in_i,
    input  logic     crc_ok_i,
    input  logic     pid_i,
    input  logic     pend_i,
    input  logic     rdy_i,
    input  logic     halted_i,
    input  logic     tog_i,
    input  logic     no_hs_i,
    output hs_code_e code_o,
    output logic     tx_o,
    output logic     acc_o,
    output logic     flip_o
);

    always_comb begin
        code_o = HS_NONE;
        tx_o   = 1'b0;
        acc_o  = 1'b0;
        flip_o = 1'b0;
        if (halted_i) begin
            code_o = HS_STALL;
        end else if (no_hs_i) begin
            if (is_in_i) tx_o  = pend_i;
            else         acc_o = crc_ok_i & rdy_i;
        end else if (is_in_i) begin
            if (pend_i) tx_o   = 1'b1;
            else        code_o = HS_NAK;
        end else if (!crc_ok_i) begin
            code_o = HS_NONE;
        end else if (!rdy_i) begin
            code_o = HS_NAK;
        end else begin
            code_o = HS_ACK;
            if (pid_i == tog_i) begin
                acc_o  = 1'b1;
                flip_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ep_hs_epreg.sv
module ep_hs_epreg
    import ep_hs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flip_i,
    input  logic set_halt_i,
    input  logic clr_halt_i,
    input  logic rst_tog_i,
    output logic halt_o,
    output logic tog_o
);

    ep_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flip_i)     st_d.tog  = ~st_q.tog;
        if (set_halt_i) st_d.halt = 1'b1;
        if (clr_halt_i) begin
            st_d.halt = 1'b0;
            st_d.tog  = 1'b0;
        end
        if (rst_tog_i)  st_d.tog  = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign halt_o = st_q.halt;
    assign tog_o  = st_q.tog;

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
    import ep_hs_pkg::*;
#(
    parameter int               NUM_EP     = 4,
    parameter logic [NUM_EP-1:0] NO_HS_MASK = 4'b1000,
    localparam int              EP_W       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              txn_valid_i,
    input  logic [EP_W-1:0]   txn_ep_i,
    input  logic              txn_in_i,
    input  logic              crc_ok_i,
    input  logic              data_pid_i,
    input  logic              pending_i,
    input  logic              buf_ready_i,
    input  logic              hack_valid_i,
    input  logic [EP_W-1:0]   hack_ep_i,
    input  logic              cmd_valid_i,
    input  logic [EP_W-1:0]   cmd_ep_i,
    input  logic [1:0]        cmd_op_i,
    output logic              hs_valid_o,
    output logic [1:0]        hs_code_o,
    output logic              tx_req_o,
    output logic              tx_pid_o,
    output logic              accept_o,
    output logic [NUM_EP-1:0] toggle_o,
    output logic [NUM_EP-1:0] halt_o
);

    logic [NUM_EP-1:0] halt_q, tog_q;
    hs_code_e          dec_code;
    logic              dec_tx, dec_acc, dec_flip;
    logic              sel_halt, sel_tog, sel_nohs;
    hs_result_t        res_d, res_q;

    assign sel_halt = halt_q[txn_ep_i];
    assign sel_tog  = tog_q[txn_ep_i];
    assign sel_nohs = NO_HS_MASK[txn_ep_i];

    ep_hs_decide u_decide (
        .is_in_i   (txn_in_i),
        .crc_ok_i  (crc_ok_i),
        .pid_i     (data_pid_i),
        .pend_i    (pending_i),
        .rdy_i     (buf_ready_i),
        .halted_i  (sel_halt),
        .tog_i     (sel_tog),
        .no_hs_i   (sel_nohs),
        .code_o    (dec_code),
        .tx_o      (dec_tx),
        .acc_o     (dec_acc),
        .flip_o    (dec_flip)
    );

    for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
        logic hit_txn, hit_hack, hit_cmd, flip;
        assign hit_txn  = txn_valid_i  && (txn_ep_i  == EP_W'(k));
        assign hit_hack = hack_valid_i && (hack_ep_i == EP_W'(k));
        assign hit_cmd  = cmd_valid_i  && (cmd_ep_i  == EP_W'(k));
        assign flip     = (hit_txn && dec_flip)
                        || (hit_hack && !halt_q[k] && !NO_HS_MASK[k]);

        ep_hs_epreg u_epreg (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .flip_i     (flip),
            .set_halt_i (hit_cmd && (cmd_op_i == CMD_SET_HALT)),
            .clr_halt_i (hit_cmd && (cmd_op_i == CMD_CLR_HALT)),
            .rst_tog_i  (hit_cmd && (cmd_op_i == CMD_RST_TOG)),
            .halt_o     (halt_q[k]),
            .tog_o      (tog_q[k])
        );
    end

    always_comb begin
        res_d = '0;
        if (txn_valid_i) begin
            res_d.valid  = 1'b1;
            res_d.code   = dec_code;
            res_d.tx     = dec_tx;
            res_d.tx_pid = sel_tog;
            res_d.acc    = dec_acc;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign hs_valid_o = res_q.valid;
    assign hs_code_o  = res_q.code;
    assign tx_req_o   = res_q.tx;
    assign tx_pid_o   = res_q.tx_pid;
    assign accept_o   = res_q.acc;
    assign toggle_o   = tog_q;
    assign halt_o     = halt_q;

endmodule

// File: rtl/ep_handshake_ctrl_chk.sv
module ep_handshake_ctrl_chk #(
    parameter int               NUM_EP     = 4,
    parameter logic [NUM_EP-1:0] NO_HS_MASK = 4'b1000,
    localparam int              EP_W       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              txn_valid_i,
    input logic [EP_W-1:0]   txn_ep_i,
    input logic              txn_in_i,
    input logic              crc_ok_i,
    input logic              hack_valid_i,
    input logic              cmd_valid_i,
    input logic [EP_W-1:0]   cmd_ep_i,
    input logic [1:0]        cmd_op_i,
    input logic              hs_valid_o,
    input logic [1:0]        hs_code_o,
    input logic              tx_req_o,
    input logic              accept_o,
    input logic [NUM_EP-1:0] toggle_o,
    input logic [NUM_EP-1:0] halt_o
);

    assert_halt_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (txn_valid_i && halt_o[txn_ep_i])
        |=> (hs_code_o == 2'd3) && !tx_req_o && !accept_o);

    assert_bad_crc_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (txn_valid_i && !txn_in_i && !crc_ok_i && !halt_o[txn_ep_i])
        |=> (hs_code_o == 2'd0) && !accept_o);

    assert_tx_no_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_req_o |-> (hs_code_o == 2'd0));

    assert_result_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txn_valid_i |=> hs_valid_o);

    assert_quiet_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!txn_valid_i && !hack_valid_i && !cmd_valid_i)
        |=> ($stable(toggle_o) && $stable(halt_o)));

    for (genvar k = 0; k < NUM_EP; k++) begin : g_chk
        assert_halt_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(halt_o[k])
            |-> $past(cmd_valid_i && (cmd_op_i == 2'd2) && (cmd_ep_i == EP_W'(k))));

        if (NO_HS_MASK[k]) begin : g_nohs
            assert_nohs_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $stable(toggle_o[k]));
        end
    end

endmodule

bind ep_handshake_ctrl ep_handshake_ctrl_chk #(
    .NUM_EP     (NUM_EP),
    .NO_HS_MASK (NO_HS_MASK)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .txn_valid_i  (txn_valid_i),
    .txn_ep_i     (txn_ep_i),
    .txn_in_i     (txn_in_i),
    .crc_ok_i     (crc_ok_i),
    .hack_valid_i (hack_valid_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ep_i     (cmd_ep_i),
    .cmd_op_i     (cmd_op_i),
    .hs_valid_o   (hs_valid_o),
    .hs_code_o    (hs_code_o),
    .tx_req_o     (tx_req_o),
    .accept_o     (accept_o),
    .toggle_o     (toggle_o),
    .halt_o       (halt_o)
);

// File: tb/ep_handshake_ctrl_bench.sv
module ep_handshake_ctrl_bench;

    localparam int NUM_EP = 4;
    localparam int EP_W   = 2;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              txn_valid_i = 1'b0;
    logic [EP_W-1:0]   txn_ep_i = '0;
    logic              txn_in_i = 1'b0;
    logic              crc_ok_i = 1'b0;
    logic              data_pid_i = 1'b0;
    logic              pending_i = 1'b0;
    logic              buf_ready_i = 1'b0;
    logic              hack_valid_i = 1'b0;
    logic [EP_W-1:0]   hack_ep_i = '0;
    logic              cmd_valid_i = 1'b0;
    logic [EP_W-1:0]   cmd_ep_i = '0;
    logic [1:0]        cmd_op_i = '0;
    logic              hs_valid_o;
    logic [1:0]        hs_code_o;
    logic              tx_req_o;
    logic              tx_pid_o;
    logic              accept_o;
    logic [NUM_EP-1:0] toggle_o;
    logic [NUM_EP-1:0] halt_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk_i = ~clk_i;

    ep_handshake_ctrl #(.NUM_EP(NUM_EP), .NO_HS_MASK(4'b1000)) u_ep_handshake_ctrl (.*);

    // vector: ep[12:11] in[10] crc[9] pid[8] pend[7] rdy[6] | code[5:4] acc[3] tx[2] txpid[1] tog[0]
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b1}, // R6 match -> ACK, flip
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd1,1'b0,1'b0,1'b0,1'b1}, // R7 mismatch -> ACK, drop
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1, 2'd0,1'b0,1'b0,1'b0,1'b1}, // R4 bad CRC
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b1}, // R5 not ready
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b0}, // R6 DATA1 match
        {2'd1,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0}, // R8 IN empty
        {2'd1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,1'b0,1'b1,1'b0,1'b0}, // R9 IN data
        {2'd3,1'b0,1'b1,1'b1,1'b0,1'b1, 2'd0,1'b1,1'b0,1'b0,1'b0}, // R10 OUT any pid
        {2'd3,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,1'b0,1'b1,1'b0,1'b0}, // R10 IN data
        {2'd3,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,1'b0,1'b0,1'b0,1'b0}, // R10 bad CRC
        {2'd2,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd1,1'b1,1'b0,1'b0,1'b1}, // R6 ep2
        {2'd2,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd0,1'b0,1'b1,1'b1,1'b1}  // R9 tx pid = toggle
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a transaction on a falling edge, sample one clock later
    task automatic txn(input logic [1:0] ep, input logic in_, input logic crc,
                       input logic pid, input logic pend, input logic rdy);
        @(negedge clk_i);
        txn_valid_i = 1'b1; txn_ep_i = ep; txn_in_i = in_; crc_ok_i = crc;
        data_pid_i = pid; pending_i = pend; buf_ready_i = rdy;
        @(negedge clk_i);
        txn_valid_i = 1'b0;
    endtask

    task automatic command(input logic [1:0] ep, input logic [1:0] op);
        @(negedge clk_i);
        cmd_valid_i = 1'b1; cmd_ep_i = ep; cmd_op_i = op;
        @(negedge clk_i);
        cmd_valid_i = 1'b0;
    endtask

    task automatic host_ack(input logic [1:0] ep);
        @(negedge clk_i);
        hack_valid_i = 1'b1; hack_ep_i = ep;
        @(negedge clk_i);
        hack_valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R11 reset valid", int'(hs_valid_o), 0);
        check("R2 reset halt", int'(halt_o), 0);
        check("R3 reset toggle", int'(toggle_o), 0);

        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            txn(v[12:11], v[10], v[9], v[8], v[7], v[6]);
            check($sformatf("R11 vec%0d valid", i), int'(hs_valid_o), 1);
            check($sformatf("R6/R10 vec%0d code", i), int'(hs_code_o), int'(v[5:4]));
            check($sformatf("R7 vec%0d accept", i), int'(accept_o), int'(v[3]));
            check($sformatf("R9 vec%0d tx", i), int'(tx_req_o), int'(v[2]));
            if (v[2]) check($sformatf("R9 vec%0d txpid", i), int'(tx_pid_o), int'(v[1]));
            check($sformatf("R6 vec%0d toggle", i), int'(toggle_o[v[12:11]]), int'(v[0]));
        end

        // R9: host acknowledge advances toggle; R10: not on no-handshake ep
        host_ack(2'd1);
        check("R9 hack toggle ep1", int'(toggle_o[1]), 1);
        host_ack(2'd3);
        check("R10 hack toggle ep3", int'(toggle_o[3]), 0);

        // R1 / R2: halt endpoint 0 after giving it toggle 1
        txn(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R6 ep0 toggle before halt", int'(toggle_o[0]), 1);
        command(2'd0, 2'd1);
        check("R2 set halt", int'(halt_o[0]), 1);
        txn(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R1 OUT stall", int'(hs_code_o), 3);
        check("R1 OUT no accept", int'(accept_o), 0);
        check("R1 OUT toggle kept", int'(toggle_o[0]), 1);
        txn(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R1 IN stall", int'(hs_code_o), 3);
        check("R1 IN no tx", int'(tx_req_o), 0);
        host_ack(2'd0);
        check("R1 hack while halted", int'(toggle_o[0]), 1);
        command(2'd0, 2'd3);
        check("R3 reset toggle keeps halt", int'(halt_o[0]), 1);
        check("R3 reset toggle value", int'(toggle_o[0]), 0);
        host_ack(2'd0);
        repeat (5) @(negedge clk_i);
        check("R2 halt persists", int'(halt_o[0]), 1);
        command(2'd0, 2'd0);
        check("R2 nop keeps halt", int'(halt_o[0]), 1);

        // R3: clear halt resets toggle; give ep0 toggle 1 first is impossible while halted,
        // so use ep2 (toggle 1) for clear-halt
        command(2'd2, 2'd1);
        command(2'd2, 2'd2);
        check("R3 clear halt ep2", int'(halt_o[2]), 0);
        check("R3 clear halt toggle ep2", int'(toggle_o[2]), 0);
        command(2'd0, 2'd2);
        check("R2 clear halt ep0", int'(halt_o[0]), 0);
        txn(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R2 ACK after clear", int'(hs_code_o), 1);
        check("R6 toggle after clear", int'(toggle_o[0]), 1);

        // R12: transaction and reset-toggle on ep1 (toggle 1) in the same cycle
        @(negedge clk_i);
        txn_valid_i = 1'b1; txn_ep_i = 2'd1; txn_in_i = 1'b0; crc_ok_i = 1'b1;
        data_pid_i = 1'b1; pending_i = 1'b0; buf_ready_i = 1'b1;
        cmd_valid_i = 1'b1; cmd_ep_i = 2'd1; cmd_op_i = 2'd3;
        @(negedge clk_i);
        txn_valid_i = 1'b0; cmd_valid_i = 1'b0;
        check("R12 code on old state", int'(hs_code_o), 1);
        check("R12 accept on old state", int'(accept_o), 1);
        check("R12 command wins toggle", int'(toggle_o[1]), 0);

        // R12: transaction with clear-halt on halted ep0 in the same cycle
        command(2'd0, 2'd1);
        @(negedge clk_i);
        txn_valid_i = 1'b1; txn_ep_i = 2'd0; txn_in_i = 1'b1; pending_i = 1'b1;
        cmd_valid_i = 1'b1; cmd_ep_i = 2'd0; cmd_op_i = 2'd2;
        @(negedge clk_i);
        txn_valid_i = 1'b0; cmd_valid_i = 1'b0;
        check("R12 stall on old halt", int'(hs_code_o), 3);
        check("R12 halt cleared", int'(halt_o[0]), 0);
        check("R12 toggle cleared", int'(toggle_o[0]), 0);

        @(negedge clk_i);
        check("R11 valid drops", int'(hs_valid_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule